// File: doc/BRIEF.md
# Cartridge Page Mapper

This block sits between a 16-bit CPU address bus and a large cartridge ROM. The ROM is built from 16 KB pages, with 8 to 64 pages (up to 1 MB). The CPU sees the ROM only in the upper half of its address space, from 8000h to FFFFh, as two 16 KB windows.

The lower window, 8000h to BFFFh, always shows the last page of the ROM. The upper window, C000h to FFFFh, shows a page held in a bank register. A CPU read of any address in the top 64 bytes (FFC0h to FFFFh) loads that register from the low address bits. The numbering counts down from the top of the ROM: FFFFh selects the last page and FFFEh the one below it. Software only reads a strobe address to change banks; no data is written.

The ROM address and chip enable are combinational functions of the current CPU address and the registered bank. The bank register changes on the clock edge that ends the selecting access.

Top module: `cart_bank_mapper`

## Requirements
- R1: For an enabled access to 8000h–BFFFh, `rom_addr` equals {PAGES−1, cpu_addr[13:0]}: the page field (upper bits) is the last page and the 14-bit offset is taken unchanged from the CPU address.
- R2: For an enabled access to C000h–FFFFh, `rom_addr` equals {bank, cpu_addr[13:0]}, where bank is the current value of the bank register.
- R3: An enabled read (`cpu_en`=1, `cpu_wr`=0) of FFC0h–FFFFh loads the bank register at the next rising clock edge with cpu_addr[5:0] masked to log2(PAGES) bits. So FFFFh gives page PAGES−1 and FFFEh gives PAGES−2.
- R4: The selecting access itself still maps through the old bank. The new bank applies from the next access onward.
- R5: Writes, cycles with `cpu_en`=0, and reads outside FFC0h–FFFFh leave the bank register unchanged. This is seen at the next C000h-window access.
- R6: After reset the bank register holds PAGES−1, so both windows show the same (last) page.
- R7: `rom_ce` is 1 exactly when `cpu_en`=1 and cpu_addr[15]=1. It is 0 for every address below 8000h.
- R8: PAGES is a power of two from 8 to 64, and `rom_addr` is 14+log2(PAGES) bits wide. With PAGES=8, the reads FFC0h and FFF8h select page 0 and FFFFh selects page 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the bank register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_en | input | 1 | An access is present on the bus this cycle |
| cpu_wr | input | 1 | 1 = write access, 0 = read access |
| cpu_addr | input | 16 | CPU address |
| rom_addr | output | 14+log2(PAGES) | ROM byte address, {page, offset} |
| rom_ce | output | 1 | ROM chip enable |

## Verification
`rom_ce` and `rom_addr` are due in the same cycle as the address, with no register on the way. The bench therefore drives each access just after a falling edge and samples the outputs 1 ns later, well before the next rising edge. A bank change is due one rising edge after the selecting read. The bench's model bank updates only after that edge, so the same-access result is checked against the old page and the next access against the new one. Two instances, one with 64 pages and one with 8, receive identical stimulus so that the masking of the page index can be compared.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;
  localparam int OFFSET_BITS = 14;
  localparam int CPU_AW      = 16;
  localparam int SEL_HI_BITS = CPU_AW - 6;
  localparam logic [SEL_HI_BITS-1:0] SEL_PREFIX = '1;

  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_FIXED  = 2'd1,
    WIN_BANKED = 2'd2
  } window_e;
endpackage

// File: rtl/bank_window_decode.sv
module bank_window_decode
  import cart_map_pkg::*;
(
  input  logic                       acc_en,
  input  logic                       acc_wr,
  input  logic [CPU_AW-1:6]          addr_hi,
  output window_e                    win,
  output logic                       sel_load
);
  always_comb begin
    if (!acc_en || !addr_hi[CPU_AW-1]) win = WIN_NONE;
    else if (addr_hi[CPU_AW-2])        win = WIN_BANKED;
    else                               win = WIN_FIXED;
  end

  assign sel_load = acc_en && !acc_wr && (addr_hi == SEL_PREFIX);
endmodule

// File: rtl/bank_page_reg.sv
module bank_page_reg #(
  parameter int PAGES = 64,
  localparam int PB = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [PB-1:0] idx,
  output logic [PB-1:0] bank
);
  localparam logic [PB-1:0] LAST_PAGE = PB'(PAGES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    bank <= LAST_PAGE;
    else if (load) bank <= idx;
  end

  assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank == $past(idx));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank));

  assert_reset_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> bank == LAST_PAGE);
endmodule

// File: rtl/rom_addr_mux.sv
module rom_addr_mux
  import cart_map_pkg::*;
#(
  parameter int PAGES = 64,
  localparam int PB = $clog2(PAGES),
  localparam int AW = OFFSET_BITS + PB
) (
  input  window_e                win,
  input  logic [PB-1:0]          bank,
  input  logic [OFFSET_BITS-1:0] offset,
  output logic [AW-1:0]          rom_addr,
  output logic                   rom_ce
);
  localparam logic [PB-1:0] LAST_PAGE = PB'(PAGES - 1);
  logic [PB-1:0] page;

  assign page     = (win == WIN_BANKED) ? bank : LAST_PAGE;
  assign rom_addr = {page, offset};
  assign rom_ce   = (win != WIN_NONE);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_map_pkg::*;
#(
  parameter int PAGES = 64
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cpu_en,
  input  logic                                cpu_wr,
  input  logic [15:0]                         cpu_addr,
  output logic [OFFSET_BITS+$clog2(PAGES)-1:0] rom_addr,
  output logic                                rom_ce
);
  localparam int PB = $clog2(PAGES);
  localparam int AW = OFFSET_BITS + PB;
  localparam logic [PB-1:0] LAST_PAGE = PB'(PAGES - 1);

  window_e       win;
  logic          sel_load;
  logic [PB-1:0] bank;

  bank_window_decode u_dec (
    .acc_en  (cpu_en),
    .acc_wr  (cpu_wr),
    .addr_hi (cpu_addr[15:6]),
    .win     (win),
    .sel_load(sel_load)
  );

  bank_page_reg #(.PAGES(PAGES)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .load (sel_load),
    .idx  (cpu_addr[PB-1:0]),
    .bank (bank)
  );

  rom_addr_mux #(.PAGES(PAGES)) u_mux (
    .win     (win),
    .bank    (bank),
    .offset  (cpu_addr[OFFSET_BITS-1:0]),
    .rom_addr(rom_addr),
    .rom_ce  (rom_ce)
  );

  assert_fixed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && cpu_addr[15:14] == 2'b10) |-> rom_addr[AW-1:OFFSET_BITS] == LAST_PAGE);

  assert_old_bank_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_en && !cpu_wr && cpu_addr[15:6] == 10'h3FF) |-> rom_addr[AW-1:OFFSET_BITS] == bank);

  assert_low_no_ce_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_addr[15] |-> !rom_ce);
endmodule

// File: tb/cart_bank_mapper_test.sv
module cart_bank_mapper_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_en = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [19:0] rom_addr;
  logic        rom_ce;
  logic [16:0] rom_addr8;
  logic        rom_ce8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int bank64 = 63;
  int bank8  = 7;

  always #(CLK_P/2) clk = ~clk;

  cart_bank_mapper #(.PAGES(64)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .rom_addr(rom_addr), .rom_ce(rom_ce));

  cart_bank_mapper #(.PAGES(8)) uut8 (
    .clk(clk), .rst_n(rst_n), .cpu_en(cpu_en), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .rom_addr(rom_addr8), .rom_ce(rom_ce8));

  function automatic int exp_addr(input logic [15:0] a, input int bank, input int pages);
    int page;
    page = a[14] ? bank : pages - 1;
    return page * 16384 + int'(a[13:0]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [15:0] a, input bit en, input bit wr, input string req);
    bit exp_ce;
    @(negedge clk);
    cpu_addr = a; cpu_en = en; cpu_wr = wr;
    #1;
    exp_ce = en && a[15];
    chk({req, "/R7 ce"}, int'(rom_ce), int'(exp_ce));
    chk({req, "/R7 ce8"}, int'(rom_ce8), int'(exp_ce));
    if (exp_ce) begin
      chk(req, int'(rom_addr), exp_addr(a, bank64, 64));
      chk({req, "/R8"}, int'(rom_addr8), exp_addr(a, bank8, 8));
    end
    @(posedge clk);
    if (en && !wr && a[15:6] == 10'h3FF) begin
      bank64 = int'(a[5:0]);
      bank8  = int'(a[2:0]);
    end
  endtask

  function automatic string tag_of(input logic [15:0] a, input bit en, input bit wr);
    if (!en || !a[15]) return "R7";
    if (!a[14]) return "R1";
    if (a[15:6] == 10'h3FF && !wr) return "R4";
    return "R2";
  endfunction

  initial begin
    void'($urandom(32'd20191));
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset ce", int'(rom_ce), 0);
    rst_n = 1'b1;

    access(16'hC123, 1, 0, "R6 reset bank");
    access(16'h8000, 1, 0, "R1 fixed low");
    access(16'hBFFF, 1, 1, "R1 fixed top");
    access(16'h7FFF, 1, 0, "R7 below window");
    access(16'hFFFE, 1, 0, "R4 old bank same access");
    access(16'hC000, 1, 0, "R3 FFFE gives second-to-last");
    access(16'hFFC0, 1, 0, "R3 FFC0");
    access(16'hD555, 1, 0, "R8 FFC0 masked to page 0");
    access(16'hFFFF, 1, 1, "R5 write ignored");
    access(16'hE000, 1, 0, "R5 after write");
    access(16'hFFFF, 0, 0, "R5 idle ignored");
    access(16'hE001, 1, 0, "R5 after idle");
    access(16'hFFBF, 1, 0, "R5 read below select range");
    access(16'hE002, 1, 0, "R5 after FFBF");
    access(16'hFFF8, 1, 0, "R8 FFF8");
    access(16'hC010, 1, 0, "R8 FFF8 masked");
    access(16'hFFFF, 1, 0, "R3 FFFF");
    access(16'hC7FF, 1, 0, "R3 top page both windows");
    access(16'h87FF, 1, 0, "R1 same page as upper");

    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      bit en, wr;
      int r;
      r = int'($urandom_range(0, 9));
      if (r < 3)      a = 16'hFFC0 | 16'($urandom_range(0, 63));
      else if (r < 8) a = 16'h8000 | 16'($urandom_range(0, 32767));
      else            a = 16'($urandom_range(0, 65535));
      en = ($urandom_range(0, 7) != 0);
      wr = ($urandom_range(0, 3) == 0);
      access(a, en, wr, tag_of(a, en, wr));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule